// File: doc/BRIEF.md
# Gated Clock Output Divider

This block takes one clock that has already been selected and drives a clock output pin from it. The output runs at the input rate divided by any integer from 1 to 16. A four-bit field sets the divisor. A single enable bit starts and stops the output without glitches.

Stopping the output is a handshake with software. Clearing the enable does not cut the output at once: a high phase that has started always runs to its full length, and the output then rests low. A read-only activity flag stays set until that stop has fully taken effect. Software polls this flag before it changes the divisor or the upstream clock source.

Software may also rewrite the divisor while the output runs. The new value is adopted only at a period boundary, so no period is ever a mix of two divisors.

Top module: `clkout_divgate`

## Requirements
- R1: While reset is held and right after it, the configuration word reads 0 and `clk_o` is low.
- R2: Configuration word layout:
  - bits 7:4 hold the divisor minus one (0 selects divide by 1, 15 selects divide by 16);
  - bit 8 is the enable;
  - bit 9 is the activity flag.
  A write sets the divisor field and the enable, and both read back from the next cycle.
- R3: Bits 31:10 and 3:0 always read 0. Writes to them, and to bit 9, have no effect on the output or on readback.
- R4: For a divisor N of 2 or more, the output has the following shape:
  - it goes high at the first input rising edge after the enabling write is registered;
  - each period lasts exactly N input cycles;
  - it is high for the first (N+1)/2 cycles of each period, rounded down, and low for the rest.
- R5: For divide by 1, `clk_o` follows `clk_i` through the gate. The first pulse comes one input cycle later than the divided case, and the gate opens and closes only while `clk_i` is low.
- R6: After the enable is cleared:
  - a high phase already under way completes in full, and a new period that begins on the same edge at which the clear is registered also completes its high phase;
  - the output then stays low;
  - no high phase is ever shortened.
- R7: The activity flag reads 1 while the enable is set or the output is still running. It drops to 0 on the same input edge at which the output makes its final fall (for N of 2 or more). For divide by 1, it drops at the input falling edge that closes the gate.
- R8: A divisor written while the output runs takes effect at the start of the next period. A write registered on a boundary edge first applies at the boundary after it.
- R9: While the enable is clear and the output has stopped, the output stays low whatever divisor is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Selected source clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 32 | Configuration word to write |
| cfg_rdata_o | output | 32 | Configuration word readback with activity flag |
| clk_o | output | 1 | Divided, gated output clock |

## Verification
Each kind of internal fault shows up at the ports within a known number of cycles:
- A divide counter that loses its place, or a divisor reloaded off a boundary, changes a sampled high or low run within one output period.
- A run flag that lags or sticks shows as a wrong activity flag, or as an extra or missing high cycle, within (N+1)/2 cycles of the disabling write.
- A gate register on the wrong edge or with the wrong condition shows in divide-by-1 mode as a pulse one input cycle early, late or missing, right after enable or disable.

The scoreboard compares both the output level and the activity flag on every input cycle of every run.

// File: rtl/cdg_pkg.sv
package cdg_pkg;
  parameter int DIV_W   = 4;
  localparam int DIV_LSB = 4;
  localparam int EN_BIT  = DIV_LSB + DIV_W;
  localparam int ST_BIT  = EN_BIT + 1;

  typedef struct packed {
    logic             en;
    logic [DIV_W-1:0] div_m;
  } cfg_t;
endpackage

// File: rtl/cdg_regs.sv
module cdg_regs
  import cdg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] rdata_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.en    <= wdata_i[EN_BIT];
      cfg_q.div_m <= wdata_i[EN_BIT-1:DIV_LSB];
    end
  end

  always_comb begin
    rdata_o                     = '0;
    rdata_o[EN_BIT-1:DIV_LSB]   = cfg_q.div_m;
    rdata_o[EN_BIT]             = cfg_q.en;
    rdata_o[ST_BIT]             = cfg_q.en | busy_i;
  end

  assign cfg_o = cfg_q;

  wire unused_bits = ^{wdata_i[DATA_W-1:ST_BIT], wdata_i[DIV_LSB-1:0]};

  // R2: an accepted write lands in the enable bit on the next cycle
  assert_en_write_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    we_i |=> (cfg_q.en == $past(wdata_i[EN_BIT])));
endmodule

// File: rtl/cdg_counter.sv
module cdg_counter
  import cdg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_m_i,
  output logic             div_q_o,
  output logic             run_o,
  output logic             act1_o
);
  logic [DIV_W-1:0] cnt_q, act_m_q, cnt_inc, half_m;
  logic             run_q, div_q, bnd, nxt_high;

  assign cnt_inc  = cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
  assign half_m   = act_m_q >> 1;
  assign bnd      = (cnt_q == act_m_q);
  assign nxt_high = bnd | (cnt_inc <= half_m);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q   <= 1'b0;
      div_q   <= 1'b0;
      cnt_q   <= '0;
      act_m_q <= '0;
    end else if (!run_q) begin
      cnt_q <= '0;
      div_q <= 1'b0;
      if (en_i) begin
        run_q   <= 1'b1;
        act_m_q <= div_m_i;
        div_q   <= (div_m_i != '0);
      end
    end else if (!en_i && (!div_q || !nxt_high)) begin
      run_q <= 1'b0;
      div_q <= 1'b0;
      cnt_q <= '0;
    end else if (bnd) begin
      cnt_q   <= '0;
      act_m_q <= div_m_i;
      div_q   <= (div_m_i != '0);
    end else begin
      cnt_q <= cnt_inc;
      div_q <= (cnt_inc <= half_m);
    end
  end

  assign div_q_o = div_q;
  assign run_o   = run_q;
  assign act1_o  = (act_m_q == '0);

  // R6: once disabled with the output low, the run ends on the next edge
  assert_stop_low_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_q && !en_i && !div_q) |=> !run_q);
  // R9: a stopped, disabled divider stays quiet
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (!run_q && !en_i) |=> (!run_q && !div_q));
  // R4: a high phase always begins at the first cycle of a period
  assert_period_start_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(div_q) |-> (cnt_q == '0));
endmodule

// File: rtl/cdg_gate.sv
module cdg_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic act1_i,
  input  logic div_q_i,
  output logic gate_o,
  output logic clk_o
);
  logic gate_q;

  always_ff @(negedge clk_i) begin
    if (rst_i) gate_q <= 1'b0;
    else       gate_q <= run_i & act1_i;
  end

  assign gate_o = gate_q;
  assign clk_o  = act1_i ? (clk_i & gate_q) : div_q_i;

  // R5: the pass-through gate opens only for a running divide-by-1
  assert_gate_open_R5: assert property (@(negedge clk_i) disable iff (rst_i)
    $rose(gate_q) |-> $past(run_i));
endmodule

// File: rtl/clkout_divgate.sv
module clkout_divgate
  import cdg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              clk_o
);
  cfg_t cfg;
  logic div_q, run, act1, gate;

  cdg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .busy_i  (run | gate),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  cdg_counter u_cnt (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (cfg.en),
    .div_m_i (cfg.div_m),
    .div_q_o (div_q),
    .run_o   (run),
    .act1_o  (act1)
  );

  cdg_gate u_gate (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .run_i   (run),
    .act1_i  (act1),
    .div_q_i (div_q),
    .gate_o  (gate),
    .clk_o   (clk_o)
  );

  // R7: an inactive flag means the pin is held low
  assert_quiet_when_idle_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !cfg_rdata_o[ST_BIT] |-> !clk_o);
endmodule

// File: tb/clkout_divgate_tb.sv
`timescale 1ns/1ps
module clkout_divgate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we  = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        clk_o;
  int          checks = 0;
  int          errors = 0;
  logic [1:0]  exp_q[$];
  string       req_q[$];

  always #2.5 clk = ~clk;

  clkout_divgate u_dut (
    .clk_i(clk), .rst_i(rst), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .clk_o(clk_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compare {clk_o, activity} each cycle during the high half of clk
  always @(posedge clk) begin
    #1.25;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk({30'd0, clk_o, rdata[9]}, {30'd0, e}, r);
    end
  end

  task automatic push(input logic c, input logic s, input string r);
    exp_q.push_back({c, s});
    req_q.push_back(r);
  endtask

  // called just after a falling edge; register write lands on the next rising edge
  task automatic wr(input logic [31:0] d);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  function automatic logic [31:0] cfgw(input int n, input logic en);
    return {22'd0, 1'b0, en, 4'(n - 1), 4'd0};
  endfunction

  task automatic push_run(input int n, input int periods, input string r);
    for (int k = 0; k < periods * n; k++) begin
      if (n == 1) push(k != 0, 1'b1, r);
      else        push((k % n) < (n + 1) / 2, 1'b1, r);
    end
  endtask

  task automatic disable_out(input int n);
    int hb;
    hb = (n == 1) ? 2 : (n + 1) / 2;
    for (int k = 0; k < hb; k++) push(1'b1, 1'b1, "R6");
    for (int k = 0; k < 3; k++)  push(1'b0, 1'b0, "R7");
    wr(cfgw(n, 1'b0));
    drain();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdata, 32'd0, "R1 reset readback");
    chk({31'd0, clk_o}, 32'd0, "R1 reset output");
    rst = 1'b0;
    @(negedge clk);
    chk(rdata, 32'd0, "R1 after release");

    // R3 / R9: reserved and status bits ignored, output quiet
    wr(32'hFFFF_FE0F);
    chk(rdata, 32'd0, "R3 reserved readback");
    for (int k = 0; k < 4; k++) push(1'b0, 1'b0, "R9");
    drain();
    wr(cfgw(6, 1'b0));
    chk(rdata, 32'h0000_0050, "R2 field readback");
    for (int k = 0; k < 6; k++) push(1'b0, 1'b0, "R9");
    drain();

    // R4 / R5 / R6 / R7 for every divisor
    for (int n = 1; n <= 16; n++) begin
      wr(cfgw(n, 1'b1));
      chk(rdata, cfgw(n, 1'b1) | 32'h200, "R2 enabled readback");
      push_run(n, 2, (n == 1) ? "R5" : "R4");
      drain();
      disable_out(n);
      chk(rdata, cfgw(n, 1'b0), "R7 stopped readback");
    end

    // R8: divisor change while running lands at the next boundary
    wr(cfgw(4, 1'b1));
    push_run(4, 2, "R4");
    drain();
    for (int k = 0; k < 4; k++) push(k < 2, 1'b1, "R8 old period");
    for (int k = 0; k < 6; k++) push((k % 3) < 2, 1'b1, "R8 new period");
    wr(cfgw(3, 1'b1));
    drain();
    disable_out(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule